// File: doc/BRIEF.md
# Thermal Sensor Calibration Coefficient Engine

This block derives the two signed 16-bit coefficients, a slope (A) and an offset (B), that program one on-die temperature sensor. The inputs are raw calibration fuse words, a per-sensor correction pair and four sampling configuration values. Calibration is taken at two points, a low-temperature point and a high-temperature point. Each point has a counter reading and a temperature. The temperatures are given in half-degree steps. The slope and offset follow from the line through those two points. A per-sensor gain (alpha, in parts per million) and a per-sensor shift (beta) then adjust both values.

A controller drives the fuse words, the correction pair and the configuration, then pulses `start` once. The engine captures every input in that cycle. It then runs four signed divisions in turn on one shared restoring divider, which produces one quotient bit per cycle. Each division rounds to nearest on a 16-bit fraction. When the last division finishes, the engine updates the coefficients and pulses `done`. If the two counter readings are equal, the line has no slope. In that case the engine does no division: it reports an error and writes zero coefficients.

Top module: `tcal_coef_engine`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is sampled, `coef_a` and `coef_b` are 0 and `done` and `err` are low.
- R2: `start` is accepted only when the engine is idle. A `start` pulse during a computation has no effect: the result then delivered belongs to the inputs captured by the earlier accepted `start`.
- R3: Fuse decoding uses these fields:
  - Sensor fuse: bits 12:0 are a signed low-point correction and bits 25:13 are a signed high-point correction.
  - Realignment fuse: bits 5:0 are a signed low-point temperature trim and bits 25:21 are a signed high-point temperature trim.
  - Shared base fuse: bits 9:0 are the unsigned low-point base and bits 20:10 are the unsigned high-point base.
  - Low count = low base × 64 + low correction. High count = high base × 32 + high correction.
  - Low temperature = 50 + low trim. High temperature = 210 + high trim.
- R4: Before correction, A = rdiv(dT × 8192 × meas_div × ref_period, dS × meas_period × ref_div). Here dS is high count − low count and dT is high temperature − low temperature.
- R5: Before correction, B = rdiv(high count × low temperature − low count × high temperature, dS).
- R6: rdiv(n, d) is (((n × 2^17) + 1) / (2 × d)), with the division truncating toward zero, followed by an arithmetic right shift by 16. All intermediate values use 64-bit two's complement arithmetic.
- R7: The final outputs are `coef_a` = low 16 bits of rdiv(A × alpha, 1000000) and `coef_b` = low 16 bits of rdiv(B × alpha + beta, 1000000). They are written, with `err` low, in the single cycle in which `done` is high. `coef_a`, `coef_b` and `err` hold their values in every other cycle.
- R8: When dS is 0, the engine drives `done` high with `err` = 1 and both coefficients 0. This happens exactly two clock edges after the edge that accepted `start`.
- R9: A `start` that is high in the same cycle as `done` is accepted and begins a new computation.
- R10: Inputs are captured when `start` is accepted. Changing any input during a computation does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| base_fuse | input | 32 | Shared base fuse word |
| realign_fuse | input | 32 | Shared temperature realignment fuse word |
| sensor_fuse | input | 32 | Per-sensor calibration fuse word |
| alpha | input | 32 | Signed per-sensor gain in ppm |
| beta | input | 32 | Signed per-sensor shift |
| cfg_meas_div | input | 16 | Measurement clock divider |
| cfg_ref_period | input | 16 | Reference sample period |
| cfg_meas_period | input | 16 | Measurement sample period |
| cfg_ref_div | input | 16 | Reference clock divider |
| coef_a | output | 16 | Slope coefficient, two's complement |
| coef_b | output | 16 | Offset coefficient, two's complement |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero-span error flag, valid with `done` |

## Verification
Result delivery and acceptance of a new request can happen in the same cycle: `done` marks the first cycle back in idle, so a `start` that is high then is taken at once. The bench waits for `done` to go high. In that same cycle it drives new inputs and raises `start`. In the next cycle it checks that the first result is still held, and later it checks that the second result matches the model for the new inputs. A `start` pulse in the middle of a computation, with changed inputs, is also sent. That test is judged by the delivered result, which must still match the first inputs.

// File: rtl/tcal_pkg.sv
`timescale 1ns/1ps
package tcal_pkg;

  localparam int unsigned WIDE  = 64;
  localparam int unsigned VAL_W = 32;

  typedef logic signed [WIDE-1:0]  wide_t;
  typedef logic signed [VAL_W-1:0] val_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV_A,
    ST_DIV_B,
    ST_COR_A,
    ST_COR_B
  } state_e;

  // Decoded two-point calibration: counter readings and half-degree temps.
  typedef struct packed {
    val_t cnt_lo;
    val_t cnt_hi;
    val_t tmp_lo;
    val_t tmp_hi;
  } cal_pts_t;

endpackage

// File: rtl/tcal_fuse_decode.sv
`timescale 1ns/1ps
module tcal_fuse_decode
  import tcal_pkg::*;
#(
  parameter int FUSE_W  = 32,
  parameter int NOM_LO  = 25,
  parameter int NOM_HI  = 105,
  parameter int LO_MUL  = 64,
  parameter int HI_MUL  = 32
) (
  input  logic [FUSE_W-1:0] base_fuse,
  input  logic [FUSE_W-1:0] realign_fuse,
  input  logic [FUSE_W-1:0] sensor_fuse,
  output cal_pts_t          pts
);

  // Field positions (decoded by neighbours, so they are fixed).
  localparam int SEN_LO_MSB = 12, SEN_LO_LSB = 0;
  localparam int SEN_HI_MSB = 25, SEN_HI_LSB = 13;
  localparam int RAL_LO_MSB = 5,  RAL_LO_LSB = 0;
  localparam int RAL_HI_MSB = 25, RAL_HI_LSB = 21;
  localparam int BAS_LO_MSB = 9,  BAS_LO_LSB = 0;
  localparam int BAS_HI_MSB = 20, BAS_HI_LSB = 10;

  function automatic val_t sfield(input logic [FUSE_W-1:0] w, input int msb, input int lsb);
    logic signed [FUSE_W-1:0] t;
    t = signed'(w << (FUSE_W - 1 - msb));
    return VAL_W'(t >>> (FUSE_W - 1 - msb + lsb));
  endfunction

  function automatic val_t ufield(input logic [FUSE_W-1:0] w, input int msb, input int lsb);
    logic [FUSE_W-1:0] t;
    t = w << (FUSE_W - 1 - msb);
    return VAL_W'(t >> (FUSE_W - 1 - msb + lsb));
  endfunction

  val_t base_lo, base_hi, corr_lo, corr_hi, trim_lo, trim_hi;

  always_comb begin
    base_lo = ufield(base_fuse, BAS_LO_MSB, BAS_LO_LSB);
    base_hi = ufield(base_fuse, BAS_HI_MSB, BAS_HI_LSB);
    corr_lo = sfield(sensor_fuse, SEN_LO_MSB, SEN_LO_LSB);
    corr_hi = sfield(sensor_fuse, SEN_HI_MSB, SEN_HI_LSB);
    trim_lo = sfield(realign_fuse, RAL_LO_MSB, RAL_LO_LSB);
    trim_hi = sfield(realign_fuse, RAL_HI_MSB, RAL_HI_LSB);

    pts.cnt_lo = base_lo * LO_MUL + corr_lo;
    pts.cnt_hi = base_hi * HI_MUL + corr_hi;
    pts.tmp_lo = 2 * NOM_LO + trim_lo;
    pts.tmp_hi = 2 * NOM_HI + trim_hi;
  end

endmodule

// File: rtl/tcal_rdiv.sv
`timescale 1ns/1ps
module tcal_rdiv #(
  parameter int DW   = 64,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic signed [DW-1:0] num,
  input  logic signed [DW-1:0] den,
  output logic                 busy,
  output logic                 valid,
  output logic signed [DW-1:0] quo
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] ITER = CW'(DW);

  logic [DW-1:0] dvd, dvs, rem;
  logic [CW-1:0] cnt;
  logic          neg;

  logic signed [DW-1:0] n_ext, d_ext, q_signed;
  logic [DW-1:0]        n_mag, d_mag, q_next;
  logic [DW:0]          shifted, trial;
  logic                 fits;

  always_comb begin
    n_ext    = (num <<< (FRAC + 1)) + DW'(1);
    d_ext    = den <<< 1;
    n_mag    = n_ext[DW-1] ? DW'(-n_ext) : DW'(n_ext);
    d_mag    = d_ext[DW-1] ? DW'(-d_ext) : DW'(d_ext);
    shifted  = {rem, dvd[DW-1]};
    trial    = shifted - {1'b0, dvs};
    fits     = ~trial[DW];
    q_next   = {dvd[DW-2:0], fits};
    q_signed = neg ? -signed'(q_next) : signed'(q_next);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd   <= '0;
      dvs   <= '0;
      rem   <= '0;
      cnt   <= '0;
      neg   <= 1'b0;
      busy  <= 1'b0;
      valid <= 1'b0;
      quo   <= '0;
    end else begin
      valid <= 1'b0;
      if (!busy) begin
        if (go) begin
          dvd  <= n_mag;
          dvs  <= d_mag;
          rem  <= '0;
          neg  <= n_ext[DW-1] ^ d_ext[DW-1];
          cnt  <= ITER;
          busy <= 1'b1;
        end
      end else begin
        dvd <= q_next;
        rem <= fits ? trial[DW-1:0] : shifted[DW-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
          quo   <= q_signed >>> FRAC;
        end
      end
    end
  end

endmodule

// File: rtl/tcal_coef_engine.sv
`timescale 1ns/1ps
module tcal_coef_engine
  import tcal_pkg::*;
#(
  parameter int FUSE_W  = 32,
  parameter int CORR_W  = 32,
  parameter int CFG_W   = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC    = 16,
  parameter int NOM_LO  = 25,
  parameter int NOM_HI  = 105,
  parameter int SLOPE_SH = 13,
  parameter int PPM     = 1000000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [FUSE_W-1:0]        base_fuse,
  input  logic [FUSE_W-1:0]        realign_fuse,
  input  logic [FUSE_W-1:0]        sensor_fuse,
  input  logic signed [CORR_W-1:0] alpha,
  input  logic signed [CORR_W-1:0] beta,
  input  logic [CFG_W-1:0]         cfg_meas_div,
  input  logic [CFG_W-1:0]         cfg_ref_period,
  input  logic [CFG_W-1:0]         cfg_meas_period,
  input  logic [CFG_W-1:0]         cfg_ref_div,
  output logic signed [COEF_W-1:0] coef_a,
  output logic signed [COEF_W-1:0] coef_b,
  output logic                     done,
  output logic                     err
);

  localparam wide_t PPM_W = wide_t'(PPM);

  state_e   state;
  cal_pts_t pts_w, pts_q;
  logic signed [CORR_W-1:0] alpha_q, beta_q;
  logic [CFG_W-1:0] mdiv_q, rper_q, mper_q, rdiv_q;
  wide_t    qa_q, qb_q, num_b_q, dsen_q;
  logic [COEF_W-1:0] a_res_q;
  logic     idle;

  logic     div_go, div_busy, div_valid;
  wide_t    div_num, div_den, div_quo;

  wide_t dsen_w, dtemp_w, mult_w, divc_w, num_a_w, den_a_w, num_b_w, cor_a_w, cor_b_w;

  tcal_fuse_decode #(
    .FUSE_W(FUSE_W), .NOM_LO(NOM_LO), .NOM_HI(NOM_HI), .LO_MUL(64), .HI_MUL(32)
  ) u_decode (
    .base_fuse   (base_fuse),
    .realign_fuse(realign_fuse),
    .sensor_fuse (sensor_fuse),
    .pts         (pts_w)
  );

  tcal_rdiv #(.DW(WIDE), .FRAC(FRAC)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .busy (div_busy),
    .valid(div_valid),
    .quo  (div_quo)
  );

  assign idle = (state == ST_IDLE);

  always_comb begin
    dsen_w  = wide_t'(pts_q.cnt_hi) - wide_t'(pts_q.cnt_lo);
    dtemp_w = wide_t'(pts_q.tmp_hi) - wide_t'(pts_q.tmp_lo);
    mult_w  = wide_t'(mdiv_q) * wide_t'(rper_q);
    divc_w  = wide_t'(mper_q) * wide_t'(rdiv_q);
    num_a_w = (dtemp_w <<< SLOPE_SH) * mult_w;
    den_a_w = dsen_w * divc_w;
    num_b_w = wide_t'(pts_q.cnt_hi) * wide_t'(pts_q.tmp_lo)
            - wide_t'(pts_q.cnt_lo) * wide_t'(pts_q.tmp_hi);
    cor_a_w = qa_q * wide_t'(alpha_q);
    cor_b_w = qb_q * wide_t'(alpha_q) + wide_t'(beta_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pts_q   <= '0;
      alpha_q <= '0;
      beta_q  <= '0;
      mdiv_q  <= '0;
      rper_q  <= '0;
      mper_q  <= '0;
      rdiv_q  <= '0;
      qa_q    <= '0;
      qb_q    <= '0;
      num_b_q <= '0;
      dsen_q  <= '0;
      a_res_q <= '0;
      div_go  <= 1'b0;
      div_num <= '0;
      div_den <= '0;
      coef_a  <= '0;
      coef_b  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pts_q   <= pts_w;
            alpha_q <= alpha;
            beta_q  <= beta;
            mdiv_q  <= cfg_meas_div;
            rper_q  <= cfg_ref_period;
            mper_q  <= cfg_meas_period;
            rdiv_q  <= cfg_ref_div;
            state   <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (dsen_w == '0) begin
            coef_a <= '0;
            coef_b <= '0;
            err    <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            num_b_q <= num_b_w;
            dsen_q  <= dsen_w;
            div_num <= num_a_w;
            div_den <= den_a_w;
            div_go  <= 1'b1;
            state   <= ST_DIV_A;
          end
        end
        ST_DIV_A: begin
          if (div_valid) begin
            qa_q    <= div_quo;
            div_num <= num_b_q;
            div_den <= dsen_q;
            div_go  <= 1'b1;
            state   <= ST_DIV_B;
          end
        end
        ST_DIV_B: begin
          if (div_valid) begin
            qb_q    <= div_quo;
            div_num <= cor_a_w;
            div_den <= PPM_W;
            div_go  <= 1'b1;
            state   <= ST_COR_A;
          end
        end
        ST_COR_A: begin
          if (div_valid) begin
            a_res_q <= div_quo[COEF_W-1:0];
            div_num <= cor_b_w;
            div_den <= PPM_W;
            div_go  <= 1'b1;
            state   <= ST_COR_B;
          end
        end
        ST_COR_B: begin
          if (div_valid) begin
            coef_a <= a_res_q;
            coef_b <= div_quo[COEF_W-1:0];
            err    <= 1'b0;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

module tcal_coef_engine_chk #(
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic              err,
  input logic              idle,
  input logic [COEF_W-1:0] coef_a,
  input logic [COEF_W-1:0] coef_b
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (coef_a == '0 && coef_b == '0 && !done && !err));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(coef_a) && $stable(coef_b) && $stable(err)));

  assert_zero_span_R8: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (coef_a == '0 && coef_b == '0));

  assert_zero_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> $past(start && idle, 2));

  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (start && idle) |=> !idle);

endmodule

bind tcal_coef_engine tcal_coef_engine_chk #(.COEF_W(COEF_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done  (done),
  .err   (err),
  .idle  (idle),
  .coef_a(coef_a),
  .coef_b(coef_b)
);

// File: tb/tcal_coef_engine_test.sv
`timescale 1ns/1ps
module tcal_coef_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_fuse = '0, realign_fuse = '0, sensor_fuse = '0;
  logic signed [31:0] alpha = '0, beta = '0;
  logic [15:0] c_md = '0, c_rp = '0, c_mp = '0, c_rd = '0;
  logic signed [15:0] coef_a, coef_b;
  logic        done, err;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  tcal_coef_engine uut (
    .clk(clk), .rst(rst), .start(start),
    .base_fuse(base_fuse), .realign_fuse(realign_fuse), .sensor_fuse(sensor_fuse),
    .alpha(alpha), .beta(beta),
    .cfg_meas_div(c_md), .cfg_ref_period(c_rp), .cfg_meas_period(c_mp), .cfg_ref_div(c_rd),
    .coef_a(coef_a), .coef_b(coef_b), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint rd(input longint n, input longint d);
    longint t;
    t = ((n <<< 16) * 2 + 1) / (2 * d);
    return t >>> 16;
  endfunction

  function automatic void model(input logic [31:0] bf, rf, sf, input int al, be,
                                input logic [15:0] md, rp, mp, rdv,
                                output logic [15:0] ea, output logic [15:0] eb,
                                output bit ee);
    longint blo, bhi, slo, shi, tlo, thi, clo, chi, ds, dt, ta, tb;
    blo = bf[9:0];
    bhi = bf[20:10];
    slo = $signed(sf[12:0]);
    shi = $signed(sf[25:13]);
    tlo = $signed(rf[5:0]);
    thi = $signed(rf[25:21]);
    clo = blo * 64 + slo;
    chi = bhi * 32 + shi;
    tlo = 50 + tlo;
    thi = 210 + thi;
    ds = chi - clo;
    dt = thi - tlo;
    if (ds == 0) begin
      ea = '0; eb = '0; ee = 1'b1;
      return;
    end
    ta = rd(dt * 8192 * (longint'(md) * longint'(rp)), ds * (longint'(mp) * longint'(rdv)));
    tb = rd(chi * tlo - clo * thi, ds);
    ta = rd(ta * al, 1000000);
    tb = rd(tb * al + be, 1000000);
    ea = ta[15:0];
    eb = tb[15:0];
    ee = 1'b0;
  endfunction

  // Called at a negedge; drives inputs and a one-cycle start.
  task automatic launch(input logic [31:0] bf, rf, sf, input int al, be,
                        input logic [15:0] md, rp, mp, rdv);
    base_fuse = bf; realign_fuse = rf; sensor_fuse = sf;
    alpha = al; beta = be;
    c_md = md; c_rp = rp; c_mp = mp; c_rd = rdv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Returns the number of negedges from the start-drive negedge to done.
  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk(1'b0, "R7", "done timeout", 0, 1);
  endtask

  task automatic check_out(input string req, input logic [15:0] ea, eb, input bit ee);
    chk(done === 1'b1, "R7", "done", done, 1);
    chk(coef_a === ea, req, "coef_a", coef_a, $signed(ea));
    chk(coef_b === eb, req, "coef_b", coef_b, $signed(eb));
    chk(err === ee, req, "err", err, ee);
  endtask

  task automatic run(input string req, input logic [31:0] bf, rf, sf, input int al, be,
                     input logic [15:0] md, rp, mp, rdv);
    logic [15:0] ea, eb;
    bit ee;
    int cyc;
    model(bf, rf, sf, al, be, md, rp, mp, rdv, ea, eb, ee);
    launch(bf, rf, sf, al, be, md, rp, mp, rdv);
    wait_done(cyc);
    check_out(req, ea, eb, ee);
    if (ee) chk(cyc == 2, "R8", "zero-span latency", cyc, 2);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done single cycle", done, 0);
    chk(coef_a === ea && coef_b === eb, "R7", "hold after done", coef_a, $signed(ea));
  endtask

  function automatic int rnd_alpha();
    return 1100000 + int'($urandom_range(0, 50000));
  endfunction

  function automatic int rnd_beta();
    return -(5500000 + int'($urandom_range(0, 1700000)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ea1, eb1, ea2, eb2;
    bit ee1, ee2;
    int cyc;
    logic [31:0] b1, r1, s1, b2, r2, s2;
    int a1, e1, a2, e2;

    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(coef_a === 16'sd0 && coef_b === 16'sd0, "R1", "coefs in reset", coef_a, 0);
    chk(done === 1'b0 && err === 1'b0, "R1", "flags in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(coef_a === 16'sd0 && coef_b === 16'sd0 && done === 1'b0 && err === 1'b0,
        "R1", "after reset", coef_a, 0);

    // R3 R4 R5 R6: signed corrections and trims, both signs
    run("R3", {11'b0, 11'd1460, 10'd590}, {6'b0, 5'h1E, 15'b0, 6'h05},
        {6'b0, 13'h1FF0, 13'h0025}, 1135400, -6266900, 16'd8, 16'd480, 16'd120, 16'd8);
    // R6: negative span exercises rounding toward zero of negative quotients
    run("R6", {11'b0, 11'd100, 10'd900}, {6'b0, 5'h0F, 15'b0, 6'h20},
        32'h0, 1122220, -5700700, 16'd8, 16'd480, 16'd120, 16'd8);

    // R8: zero span, then a normal run clears err
    run("R8", 32'h0, 32'h0, 32'h0, 1127000, -6768200, 16'd8, 16'd480, 16'd120, 16'd8);
    run("R8", {11'b0, 11'd2, 10'd1}, 32'h0, 32'h0, 1110900, -6232000, 16'd8, 16'd480, 16'd120, 16'd8);
    run("R7", {11'b0, 11'd1500, 10'd600}, 32'h0, 32'h0, 1122300, -5936400, 16'd8, 16'd480, 16'd120, 16'd8);

    // R4 R5: random fuses, default sampling configuration
    for (int i = 0; i < 20; i++) begin
      run("R4", $urandom, $urandom, $urandom, rnd_alpha(), rnd_beta(),
          16'd8, 16'd480, 16'd120, 16'd8);
    end
    // R4: random sampling configuration
    for (int i = 0; i < 8; i++) begin
      run("R4", $urandom, $urandom, $urandom, rnd_alpha(), rnd_beta(),
          16'($urandom_range(1, 16)), 16'($urandom_range(1, 1023)),
          16'($urandom_range(1, 255)), 16'($urandom_range(1, 16)));
    end
    // R5: realistic fuse neighbourhood, small random corrections
    for (int i = 0; i < 6; i++) begin
      run("R5", {11'b0, 11'($urandom_range(1400, 1600)), 10'($urandom_range(550, 650))},
          $urandom, {6'b0, 13'($urandom_range(0, 8191)), 13'($urandom_range(0, 8191))},
          rnd_alpha(), rnd_beta(), 16'd8, 16'd480, 16'd120, 16'd8);
    end

    // R2 R10: second start mid-run with new inputs is ignored
    b1 = $urandom; r1 = $urandom; s1 = $urandom; a1 = rnd_alpha(); e1 = rnd_beta();
    b2 = $urandom; r2 = $urandom; s2 = $urandom; a2 = rnd_alpha(); e2 = rnd_beta();
    model(b1, r1, s1, a1, e1, 16'd8, 16'd480, 16'd120, 16'd8, ea1, eb1, ee1);
    launch(b1, r1, s1, a1, e1, 16'd8, 16'd480, 16'd120, 16'd8);
    repeat (5) @(negedge clk);
    launch(b2, r2, s2, a2, e2, 16'd3, 16'd77, 16'd9, 16'd5);
    wait_done(cyc);
    check_out("R2", ea1, eb1, ee1);
    chk(cyc > 8, "R10", "no early completion", cyc, 9);
    @(negedge clk);
    chk(done === 1'b0, "R2", "no second result", done, 0);

    // R9: start in the done cycle is accepted
    model(b2, r2, s2, a2, e2, 16'd8, 16'd480, 16'd120, 16'd8, ea2, eb2, ee2);
    launch(b1, r1, s1, a1, e1, 16'd8, 16'd480, 16'd120, 16'd8);
    wait_done(cyc);
    check_out("R9", ea1, eb1, ee1);
    launch(b2, r2, s2, a2, e2, 16'd8, 16'd480, 16'd120, 16'd8);
    chk(coef_a === ea1 && coef_b === eb1, "R7", "hold during next run", coef_a, $signed(ea1));
    wait_done(cyc);
    check_out("R9", ea2, eb2, ee2);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule